// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one SDRAM burst, one per clock. A single-cycle start pulse captures a 10-bit start column, a burst length code and an ordering flag (sequential or interleaved). From the cycle after the pulse, the block drives one column per cycle with a valid flag. It raises a last flag on the final beat of a fixed-length burst.

Short bursts stay inside an aligned block whose size equals the burst length. The column bits above that block never change during the burst. Only the low bits step, either by adding the beat number modulo the length or by XOR-ing the beat number into the start offset.

A full-page burst walks all 1024 columns from any start, wrapping from 1023 to 0. It keeps going until it is stopped. A stop input ends any burst early. A command engine uses the block to drive the address pins of the column phase.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, col_last and cfg_err are all 0 and stay 0 until a start pulse.
- R2: Length codes on len_code are 0 (one beat), 1 (two beats), 2 (four), 3 (eight), and 4 to 7 (full page). In the cycle after start is high at a clock edge, col_valid is 1 and col_out equals the captured start column. A fixed-length burst then gives exactly one new column per cycle.
- R3: With ilv = 0 and a length L of 2, 4 or 8, the low log2(L) bits of beat k equal (start offset + k) mod L. The upper column bits equal those of the start column on every beat.
- R4: With ilv = 1 and a length L of 2, 4 or 8, the low log2(L) bits of beat k equal the start offset XOR k. For example, start 5 at length 8 gives 5,4,7,6,1,0,3,2.
- R5: With len_code 0, one beat carrying the start column is produced, with col_last = 1, whatever the value of ilv.
- R6: col_last is 1 only on beat L-1 of a fixed-length burst. col_valid is 0 in the cycle after that beat unless a new start was taken.
- R7: A full-page burst gives (start + k) mod 1024 on beat k. It never raises col_last and keeps running past 1024 beats until stopped.
- R8: A start with ilv = 1 and a full-page code runs in sequential order and sets cfg_err. Every other start clears cfg_err. cfg_err holds until the next start.
- R9: If stop is 1 at a clock edge while a burst is running, the beat shown in that cycle is the final one. col_valid is 0 in the next cycle. This holds for every burst length.
- R10: If start is 1 at an edge, it takes priority over stop and over a burst in progress. The next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the burst parameters and begins a burst |
| start_col | input | 10 | First column of the burst |
| len_code | input | 3 | Burst length code (see R2) |
| ilv | input | 1 | 1 selects interleaved ordering, 0 sequential |
| stop | input | 1 | Ends a running burst after the current beat |
| col_out | output | 10 | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat of a burst |
| col_last | output | 1 | Current beat is the natural final beat |
| cfg_err | output | 1 | Last start asked for interleaved full page |

## Verification
Two events can meet in one cycle: a new start pulse, and either a stop or the natural last beat of the running burst. The bench raises start and stop together in the middle of an eight-beat burst, and also starts a new burst exactly on the last beat of a four-beat one. In both cases the following cycle must show a valid beat 0 carrying the new start column. After that, the new burst must follow its own ordering, not end. Stop alone on an ordinary beat, and stop during a full page that has wrapped, must each leave col_valid low one cycle later.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    parameter int COL_BITS = 10;
    parameter int CODE_BITS = 3;

    typedef logic [COL_BITS-1:0] col_t;

    typedef enum logic [CODE_BITS-1:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd4
    } blen_e;

    typedef struct packed {
        col_t base;
        col_t offs;
        col_t mask;
        col_t last_idx;
        logic xor_mode;
        logic page;
    } burst_cfg_t;

    function automatic logic is_page(logic [CODE_BITS-1:0] code);
        return code >= BL_PAGE;
    endfunction

    function automatic col_t wrap_mask(logic [CODE_BITS-1:0] code);
        col_t m;
        if (is_page(code)) m = '1;
        else m = col_t'((1 << code) - 1);
        return m;
    endfunction

    function automatic col_t beat_addr(burst_cfg_t c, col_t beat);
        col_t o;
        o = c.xor_mode ? (c.offs ^ beat) : (c.offs + beat);
        return c.base | (o & c.mask);
    endfunction

endpackage

// File: rtl/bcs_cfg_capture.sv
module bcs_cfg_capture
    import bcs_pkg::*;
#(
    parameter int CW = COL_BITS,
    parameter int LW = CODE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_col,
    input  logic [LW-1:0] len_code,
    input  logic          ilv,
    output burst_cfg_t    cfg,
    output logic          cfg_err
);
    burst_cfg_t nxt;
    logic       page_req;

    always_comb begin
        page_req     = is_page(len_code);
        nxt.mask     = wrap_mask(len_code);
        nxt.base     = start_col & ~nxt.mask;
        nxt.offs     = start_col & nxt.mask;
        nxt.last_idx = nxt.mask;
        nxt.page     = page_req;
        // single beat ignores ordering; full page forces sequential
        nxt.xor_mode = ilv && !page_req && (len_code != BL_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cfg_err <= 1'b0;
        end else if (start) begin
            cfg     <= nxt;
            cfg_err <= ilv && page_req;
        end
    end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
    import bcs_pkg::*;
#(
    parameter int CW = COL_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] last_idx,
    input  logic          page,
    output logic          active,
    output logic [CW-1:0] beat,
    output logic          at_end
);
    assign at_end = active && !page && (beat == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat   <= '0;
        end else if (active) begin
            if (stop || at_end) begin
                active <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int CW = COL_BITS
) (
    input  burst_cfg_t    cfg,
    input  logic [CW-1:0] beat,
    output logic [CW-1:0] col
);
    assign col = beat_addr(cfg, beat);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int CW = COL_BITS,
    parameter int LW = CODE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_col,
    input  logic [LW-1:0] len_code,
    input  logic          ilv,
    input  logic          stop,
    output logic [CW-1:0] col_out,
    output logic          col_valid,
    output logic          col_last,
    output logic          cfg_err
);
    burst_cfg_t    cfg;
    logic          active;
    logic          at_end;
    logic [CW-1:0] beat;

    bcs_cfg_capture #(.CW(CW), .LW(LW)) u_cfg (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .ilv(ilv), .cfg(cfg), .cfg_err(cfg_err)
    );

    bcs_beat_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .last_idx(cfg.last_idx), .page(cfg.page),
        .active(active), .beat(beat), .at_end(at_end)
    );

    bcs_addr_gen #(.CW(CW)) u_addr (
        .cfg(cfg), .beat(beat), .col(col_out)
    );

    assign col_valid = active;
    assign col_last  = at_end;
endmodule

// File: rtl/bcs_checks.sv
module bcs_checks
    import bcs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [COL_BITS-1:0]  start_col,
    input logic [CODE_BITS-1:0] len_code,
    input logic                 ilv,
    input logic                 stop,
    input logic [COL_BITS-1:0]  col_out,
    input logic                 col_valid,
    input logic                 col_last,
    input logic                 cfg_err
);
    col_t chk_mask;
    logic chk_page;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_mask <= '0;
            chk_page <= 1'b0;
        end else if (start) begin
            chk_mask <= wrap_mask(len_code);
            chk_page <= is_page(len_code);
        end
    end

    AST_START_BEAT: assert property (@(posedge clk) disable iff (rst)
        start |=> (col_valid && col_out == $past(start_col))); // R2

    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !stop && !col_last && !start) |=>
        (col_valid && ((col_out & ~chk_mask) == ($past(col_out) & ~chk_mask)))); // R3

    AST_LAST_DROPS: assert property (@(posedge clk) disable iff (rst)
        (col_last && !start) |=> !col_valid); // R6

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid); // R6

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (rst)
        (col_valid && chk_page) |-> !col_last); // R7

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (col_valid && chk_page && !stop && !start) |=>
        (col_valid && col_out == $past(col_out) + 1'b1)); // R7

    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        start |=> (cfg_err == ($past(ilv) && ($past(len_code) >= 3'd4)))); // R8

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
        (col_valid && stop && !start) |=> !col_valid); // R9
endmodule

bind burst_col_seq bcs_checks i_bcs_checks (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .stop(stop), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .cfg_err(cfg_err)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       ilv = 1'b0;
    logic       stop = 1'b0;
    logic [9:0] col_out;
    logic       col_valid, col_last, cfg_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .ilv(ilv), .stop(stop), .col_out(col_out),
        .col_valid(col_valid), .col_last(col_last), .cfg_err(cfg_err)
    );

    function automatic logic [9:0] model(logic [9:0] sc, logic [2:0] code,
                                         logic il, int k);
        int m;
        int off;
        int o;
        if (code >= 3'd4) return 10'((int'(sc) + k) % 1024);
        m = (1 << code) - 1;
        off = int'(sc) & m;
        o = (il && code != 0) ? (off ^ k) : ((off + k) & m);
        return 10'((int'(sc) & ~m) | o);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic kick(logic [9:0] sc, logic [2:0] code, logic il, logic st);
        start = 1'b1; start_col = sc; len_code = code; ilv = il; stop = st;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
    endtask

    // checks beats 0..n-1 of a burst whose beat 0 is visible now
    task automatic walk(string req, logic [9:0] sc, logic [2:0] code,
                        logic il, int n, bit fixed_len);
        for (int k = 0; k < n; k++) begin
            chk(col_valid && col_out == model(sc, code, il, k), req,
                int'(col_out), int'(model(sc, code, il, k)));
            if (fixed_len)
                chk(col_last == (k == n - 1), "R6", int'(col_last), int'(k == n - 1));
            if (k < n - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!col_valid && !col_last && !cfg_err, "R1",
            {col_valid, col_last, cfg_err}, 0);
        @(negedge clk);
        chk(!col_valid, "R1", int'(col_valid), 0);
    endtask

    task automatic t_fixed(logic [9:0] sc, logic [2:0] code, logic il, string req);
        @(negedge clk);
        kick(sc, code, il, 1'b0);
        chk(col_out == sc, "R2", int'(col_out), int'(sc));
        walk(req, sc, code, il, 1 << code, 1'b1);
        @(negedge clk);
        chk(!col_valid, "R6", int'(col_valid), 0);
        chk(cfg_err == 1'b0, "R8", int'(cfg_err), 0);
    endtask

    task automatic t_page(logic [9:0] sc, logic il);
        @(negedge clk);
        kick(sc, 3'd4, il, 1'b0);
        chk(cfg_err == il, "R8", int'(cfg_err), int'(il));
        for (int k = 0; k < 1030; k++) begin
            chk(col_valid && col_out == model(sc, 3'd4, 1'b0, k) && !col_last, "R7",
                int'(col_out), int'(model(sc, 3'd4, 1'b0, k)));
            if (k == 1029) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        chk(!col_valid, "R9", int'(col_valid), 0);
        chk(cfg_err == il, "R8", int'(cfg_err), int'(il));
    endtask

    task automatic t_stop(logic [2:0] code, int at);
        @(negedge clk);
        kick(10'd99, code, 1'b0, 1'b0);
        for (int k = 0; k < at; k++) @(negedge clk);
        chk(col_valid && col_out == model(10'd99, code, 1'b0, at), "R9",
            int'(col_out), int'(model(10'd99, code, 1'b0, at)));
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!col_valid, "R9", int'(col_valid), 0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        kick(10'd40, 3'd3, 1'b0, 1'b0);
        @(negedge clk);
        // start and stop together at beat 1: start wins
        kick(10'd22, 3'd2, 1'b1, 1'b1);
        walk("R10", 10'd22, 3'd2, 1'b1, 4, 1'b1);
        // new start exactly on the last beat
        kick(10'd13, 3'd3, 1'b1, 1'b0);
        walk("R10", 10'd13, 3'd3, 1'b1, 8, 1'b1);
        @(negedge clk);
        chk(!col_valid, "R6", int'(col_valid), 0);
    endtask

    task automatic t_single();
        @(negedge clk);
        kick(10'd517, 3'd0, 1'b1, 1'b0);
        chk(col_valid && col_last && col_out == 10'd517, "R5", int'(col_out), 517);
        @(negedge clk);
        chk(!col_valid, "R5", int'(col_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fixed(10'd5,   3'd3, 1'b0, "R3");
        t_fixed(10'd5,   3'd3, 1'b1, "R4");
        t_fixed(10'd302, 3'd2, 1'b0, "R3");
        t_fixed(10'd303, 3'd2, 1'b1, "R4");
        t_fixed(10'd1023,3'd1, 1'b0, "R3");
        t_fixed(10'd1023,3'd1, 1'b1, "R4");
        t_fixed(10'd886, 3'd3, 1'b1, "R4");
        t_single();
        t_page(10'd1020, 1'b0);
        t_page(10'd7,    1'b1);
        t_stop(3'd3, 2);
        t_stop(3'd1, 0);
        t_collide();
        t_fixed(10'd0,   3'd2, 1'b0, "R2");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule